// File: doc/BRIEF.md
# Table-Driven Saturating Angle Counter Pair

This block holds two independent angle counters, each 9 bits wide and confined to 0 through 359 degrees. Neither counter contains an adder or a comparator. Every next value is read from a next-state table in a synchronous dual-port read-only memory. The table is computed once at elaboration, and the memory has no write path. Each counter owns one memory port. The count sits in that port's output register and is fed back into the port's read address, so each port works as a small state machine whose transitions are all stored in memory.

The read address of a port is 11 bits wide. From most to least significant bit it holds the enable, the direction and the present count. Counting up stops at 359 and counting down stops at 0. When enable is low the count holds. Each port has its own clock, its own synchronous active-low reset, its own enable and its own direction. Reset clears the output register even when enable is low, because the port's register enable is driven by enable OR reset.

Top module: `angle_table_counter_pair`

## Requirements
- R1: When the port's reset input is low at a rising edge of that port's clock, the port's angle output is 0 after that edge, whatever the enable and direction inputs are.
- R2: With enable high and direction high (1 = up), an angle below 359 increases by exactly 1 at the next rising edge of the port's clock.
- R3: With enable high and direction low (0 = down), an angle above 0 decreases by exactly 1 at the next rising edge of the port's clock.
- R4: With enable high and direction up, an angle of 359 stays at 359.
- R5: With enable high and direction down, an angle of 0 stays at 0.
- R6: With enable low and reset high, the angle keeps its value whatever the direction input does.
- R7: After the first reset, the angle output never exceeds 359.
- R8: The two ports are independent. Resetting, enabling or stepping one port has no effect on the other port's angle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock of counter A |
| rst_n_a | input | 1 | Synchronous active-low reset of counter A |
| en_a | input | 1 | Count enable of counter A |
| up_a | input | 1 | Direction of counter A (1 = up, 0 = down) |
| angle_a | output | 9 | Present angle of counter A |
| clk_b | input | 1 | Clock of counter B |
| rst_n_b | input | 1 | Synchronous active-low reset of counter B |
| en_b | input | 1 | Count enable of counter B |
| up_b | input | 1 | Direction of counter B (1 = up, 0 = down) |
| angle_b | output | 9 | Present angle of counter B |

## Verification
The assertions assume that each port receives at least one reset edge before its count is relied on. Until then the output register holds no defined value, so every stepping and range property is switched off while that port's reset is low. They also assume that enable, direction and reset are stable around the port's own clock edge. The bench meets both assumptions: it starts each run with a reset on both ports, and it changes every input shortly after the rising edge of the clock it belongs to, never near the other port's edge.

// File: rtl/angle_tbl_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the elaboration-time next-state function.
// Assumes ANGLE_MAX < 2**CNT_W. Address layout: {enable, up, count}.
package angle_tbl_pkg;
    localparam int CNT_W     = 9;
    localparam int ANGLE_MAX = 359;
    localparam int ADDR_W    = CNT_W + 2;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int N_PORTS   = 2;

    // Next count for one table address; used only to build constants.
    function automatic logic [CNT_W-1:0] table_entry(input int unsigned a);
        logic [ADDR_W-1:0] av;
        int unsigned       c;
        av = ADDR_W'(a);
        c  = int'(av[CNT_W-1:0]);
        if (c > ANGLE_MAX)     return '0;            // unreachable codes recover to 0
        if (!av[ADDR_W-1])     return CNT_W'(c);     // enable low: hold
        if (av[ADDR_W-2])      return (c == ANGLE_MAX) ? CNT_W'(c) : CNT_W'(c + 1);
        return (c == 0) ? '0 : CNT_W'(c - 1);
    endfunction
endpackage

// File: rtl/angle_addr_form.sv
`timescale 1ns/1ps
// Module: forms one port's table address and its register enable.
// The enable is widened by reset so a reset clears the register while
// the counter is otherwise disabled (reset outranks enable).
module angle_addr_form
    import angle_tbl_pkg::*;
(
    input  logic              rst_n,
    input  logic              en,
    input  logic              up,
    input  logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] addr,
    output logic              ce
);
    // Address concatenation: enable, direction, present count.
    always_comb addr = {en, up, cnt};

    // Register enable: counting or resetting.
    always_comb ce = en | ~rst_n;
endmodule

// File: rtl/angle_table_mem.sv
`timescale 1ns/1ps
// Module: read-only multi-port synchronous memory holding the next-state
// table. Each port has its own clock, enable and synchronous active-low
// reset acting on the output register. No write path exists.
module angle_table_mem
    import angle_tbl_pkg::*;
#(
    parameter int NP = N_PORTS,
    parameter int AW = ADDR_W,
    parameter int DW = CNT_W
) (
    input  logic [NP-1:0]         clk,
    input  logic [NP-1:0]         rst_n,
    input  logic [NP-1:0]         ce,
    input  logic [NP-1:0][AW-1:0] addr,
    output logic [NP-1:0][DW-1:0] dout
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] tbl [WORDS];

    // Table contents, fixed at elaboration.
    for (genvar i = 0; i < WORDS; i++) begin : g_fill
        assign tbl[i] = DW'(table_entry(i));
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic [DW-1:0] q;

        // Output register: reset wins, otherwise load the addressed word.
        always_ff @(posedge clk[p]) begin
            if (ce[p]) begin
                if (!rst_n[p]) q <= '0;
                else           q <= tbl[addr[p]];
            end
        end

        assign dout[p] = q;
    end
endmodule

// File: rtl/angle_table_counter_pair.sv
`timescale 1ns/1ps
// Module: two saturating 0..359 angle counters sharing one table memory.
// Each count is the memory's output register, looped back into its own
// read address. Assumes each port is reset before its count is used.
module angle_table_counter_pair
    import angle_tbl_pkg::*;
(
    input  logic             clk_a,
    input  logic             rst_n_a,
    input  logic             en_a,
    input  logic             up_a,
    output logic [CNT_W-1:0] angle_a,
    input  logic             clk_b,
    input  logic             rst_n_b,
    input  logic             en_b,
    input  logic             up_b,
    output logic [CNT_W-1:0] angle_b
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(ANGLE_MAX);

    logic [N_PORTS-1:0]             clk_v, rst_n_v, en_v, up_v, ce_v;
    logic [N_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [N_PORTS-1:0][CNT_W-1:0]  angle_v;

    // Gather the per-port pins into vectors.
    always_comb begin
        clk_v   = {clk_b, clk_a};
        rst_n_v = {rst_n_b, rst_n_a};
        en_v    = {en_b, en_a};
        up_v    = {up_b, up_a};
    end

    assign angle_a = angle_v[0];
    assign angle_b = angle_v[1];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_ctr
        angle_addr_form u_addr (
            .rst_n (rst_n_v[p]),
            .en    (en_v[p]),
            .up    (up_v[p]),
            .cnt   (angle_v[p]),
            .addr  (addr_v[p]),
            .ce    (ce_v[p])
        );

        // Reset clears regardless of enable (R1).
        p_reset_clear_r1: assert property (@(posedge clk_v[p])
            !rst_n_v[p] |=> angle_v[p] == '0);

        // Step up by one below the ceiling (R2).
        p_step_up_r2: assert property (@(posedge clk_v[p]) disable iff (!rst_n_v[p])
            (en_v[p] && up_v[p] && angle_v[p] < TOP) |=> angle_v[p] == $past(angle_v[p]) + ONE);

        // Step down by one above zero (R3).
        p_step_down_r3: assert property (@(posedge clk_v[p]) disable iff (!rst_n_v[p])
            (en_v[p] && !up_v[p] && angle_v[p] != '0) |=> angle_v[p] == $past(angle_v[p]) - ONE);

        // Ceiling holds (R4).
        p_sat_top_r4: assert property (@(posedge clk_v[p]) disable iff (!rst_n_v[p])
            (en_v[p] && up_v[p] && angle_v[p] == TOP) |=> angle_v[p] == TOP);

        // Floor holds (R5).
        p_sat_zero_r5: assert property (@(posedge clk_v[p]) disable iff (!rst_n_v[p])
            (en_v[p] && !up_v[p] && angle_v[p] == '0) |=> angle_v[p] == '0);

        // Disabled counter holds (R6).
        p_hold_r6: assert property (@(posedge clk_v[p]) disable iff (!rst_n_v[p])
            !en_v[p] |=> $stable(angle_v[p]));

        // Never outside the legal range (R7).
        p_in_range_r7: assert property (@(posedge clk_v[p]) disable iff (!rst_n_v[p])
            angle_v[p] <= TOP);
    end

    angle_table_mem #(
        .NP (N_PORTS),
        .AW (ADDR_W),
        .DW (CNT_W)
    ) u_mem (
        .clk   (clk_v),
        .rst_n (rst_n_v),
        .ce    (ce_v),
        .addr  (addr_v),
        .dout  (angle_v)
    );
endmodule

// File: tb/angle_table_counter_pair_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each comparing both ports with a
// behavioural reference count after every clock edge of the stepped port.
module angle_table_counter_pair_tb_top;
    logic       clk_a = 1'b0, clk_b = 1'b0;
    logic       rst_n_a = 1'b0, en_a = 1'b0, up_a = 1'b0;
    logic       rst_n_b = 1'b0, en_b = 1'b0, up_b = 1'b0;
    logic [8:0] angle_a, angle_b;

    int n_cmp = 0;
    int n_bad = 0;
    int mdl [2];
    bit done = 1'b0;
    int unsigned seed = 32'h1234_5678;

    always #5 clk_a = ~clk_a;
    initial begin
        #2.5;
        forever #5 clk_b = ~clk_b;
    end

    angle_table_counter_pair dut_i (
        .clk_a (clk_a), .rst_n_a (rst_n_a), .en_a (en_a), .up_a (up_a), .angle_a (angle_a),
        .clk_b (clk_b), .rst_n_b (rst_n_b), .en_b (en_b), .up_b (up_b), .angle_b (angle_b)
    );

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    task automatic chk(input int p, input string tag);
        int got;
        got = (p == 0) ? int'(angle_a) : int'(angle_b);
        n_cmp++;
        if (got != mdl[p]) begin
            n_bad++;
            $display("FAIL %s port %0d: got %0d expected %0d", tag, p, got, mdl[p]);
        end
    endtask

    // Drive one port for one of its clock edges, update model, check both ports.
    task automatic step(input int p, input bit rn, input bit en, input bit up, input string tag);
        if (p == 0) begin rst_n_a = rn; en_a = en; up_a = up; @(posedge clk_a); end
        else        begin rst_n_b = rn; en_b = en; up_b = up; @(posedge clk_b); end
        if (!rn)     mdl[p] = 0;
        else if (en) mdl[p] = up ? ((mdl[p] == 359) ? 359 : mdl[p] + 1)
                                 : ((mdl[p] == 0) ? 0 : mdl[p] - 1);
        #1;
        chk(p, tag);
        chk(1 - p, "R8");
    endtask

    task automatic t_reset();
        step(0, 1'b0, 1'b0, 1'b0, "R1");
        step(1, 1'b0, 1'b0, 1'b1, "R1");
        for (int i = 0; i < 5; i++) step(0, 1'b1, 1'b1, 1'b1, "R2");
        step(0, 1'b0, 1'b0, 1'b1, "R1");   // reset with enable low
        for (int i = 0; i < 3; i++) step(0, 1'b1, 1'b1, 1'b1, "R2");
        step(0, 1'b0, 1'b1, 1'b1, "R1");   // reset with enable high
    endtask

    task automatic t_up_to_top();
        for (int i = 0; i < 400; i++) step(0, 1'b1, 1'b1, 1'b1, (mdl[0] == 359) ? "R4" : "R2");
        step(0, 1'b1, 1'b1, 1'b1, "R4");
    endtask

    task automatic t_down_to_zero();
        for (int i = 0; i < 400; i++) step(0, 1'b1, 1'b1, 1'b0, (mdl[0] == 0) ? "R5" : "R3");
        step(0, 1'b1, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 40; i++) step(1, 1'b1, 1'b1, 1'b1, "R2");
        for (int i = 0; i < 20; i++) step(1, 1'b1, 1'b0, i[0], "R6");
    endtask

    task automatic t_independent();
        fork
            for (int i = 0; i < 60; i++) step(0, (i != 30), 1'b1, 1'b1, (i == 30) ? "R1" : "R2");
            for (int i = 0; i < 60; i++) step(1, 1'b1, 1'b1, 1'b0, "R3");
        join
    endtask

    task automatic t_random();
        fork
            for (int p = 0; p < 2; p++) begin
                automatic int pp = p;
                fork
                    begin
                        bit up_d = 1'b1;
                        for (int run = 0; run < 40; run++) begin
                            int len = 1 + int'(rnd() % 120);
                            up_d = rnd() % 2 == 0;
                            for (int k = 0; k < len; k++)
                                step(pp, (rnd() % 500) != 0, (rnd() % 8) != 0, up_d, "R7");
                        end
                    end
                join_none
            end
        join
        wait fork;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        mdl[0] = 0;
        mdl[1] = 0;
        #1;
        t_reset();
        t_up_to_top();
        t_down_to_zero();
        t_hold();
        t_independent();
        t_random();
        finish_run();
    end

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule